// File: doc/BRIEF.md
# Bidirectional Bus Transfer Register

This block is a word-wide storage register placed between two parallel ports, called A and B, with one serial input and one serial output as well. A direction control picks which port supplies data and which port presents the stored word. An enable input gates port A only, so several of these registers can share one A bus. A mode input chooses between parallel transfer and serial shifting. A second mode input decides whether a parallel transfer waits for the rising clock edge or follows the source port at once.

Typical uses are moving a word from one bus to the other, gathering a serial stream into a word and presenting it on either bus, recirculating a stored word by feeding the serial output back to the serial input, and loading a word from a bus and then shifting it out bit by bit. Each port is split into separate input, output and output-enable signals. The tri-state pad that merges them sits outside the block.

Top module: `bus_xfer_reg`

## Requirements
- R1: A synchronous active-high reset clears every stage of the stored word to zero by the next rising clock edge.
- R2: With the direction input at 1, port A is the source and port B is the output, so `b_oe`=1 and `a_oe`=0. With the direction input at 0, port B is the source and port A is the output, so `b_oe`=0 and `a_oe` equals the A-enable.
- R3: With the A-enable at 0, port A neither supplies data nor drives: `a_oe` stays 0, and a parallel load from A leaves the stored word unchanged.
- R4: With parallel mode at 1 and the async-select input at 0, the word on the source port is stored on the rising clock edge and is visible after that edge.
- R5: With parallel mode at 1 and async-select at 1, the presented word equals the source port within the same cycle, with no clock edge needed.
- R6: When the asynchronous parallel mode is left after it has been held across at least one rising edge, the word last taken from the source is held.
- R7: With parallel mode at 0, each rising edge shifts the word one place from bit 0 toward bit WIDTH-1. `ser_in` enters bit 0, `ser_out` is bit WIDTH-1, and async-select has no effect.
- R8: With parallel mode at 1 and no usable source (A is the source and the A-enable is 0), the stored word is kept across clock edges.
- R9: `a_out` and `b_out` both carry the stored word, and `ser_out` tracks its top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Port A enable |
| dir_a2b | input | 1 | 1: A supplies and B outputs; 0: B supplies and A outputs |
| par_mode | input | 1 | 1: parallel transfer; 0: serial shift |
| async_par | input | 1 | 1: parallel transfer follows the source without waiting for the clock |
| ser_in | input | 1 | Serial data into bit 0 |
| a_in | input | WIDTH | Port A input side |
| a_out | output | WIDTH | Port A output side |
| a_oe | output | 1 | Port A output enable |
| b_in | input | WIDTH | Port B input side |
| b_out | output | WIDTH | Port B output side |
| b_oe | output | 1 | Port B output enable |
| ser_out | output | 1 | Serial data from bit WIDTH-1 |

## Verification
The bench builds the block with WIDTH = 8. At that width a full serial fill and a full serial drain each take eight edges, so both complete inside a short run, and a recirculation pass brings the word back to its starting value. A behavioural reference word is compared against both ports and the serial output in every cycle. Each cycle is sampled once before its clock edge, so the level-sensitive parallel path is seen during the same cycle in which it is selected.

// File: rtl/bxr_pkg.sv
package bxr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_TRACK = 2'd3
  } op_e;

  function automatic op_e pick_op(input logic par, input logic async_sel,
                                  input logic src_ok);
    op_e r;
    if (!par)                 r = OP_SHIFT;
    else if (!src_ok)         r = OP_HOLD;
    else if (async_sel)       r = OP_TRACK;
    else                      r = OP_LOAD;
    return r;
  endfunction

  function automatic logic source_usable(input logic a_is_src, input logic a_enable);
    return a_is_src ? a_enable : 1'b1;
  endfunction

endpackage

// File: rtl/bxr_ctrl.sv
module bxr_ctrl
  import bxr_pkg::*;
(
  input  logic a_en,
  input  logic dir_a2b,
  input  logic par_mode,
  input  logic async_par,
  output op_e  op,
  output logic src_is_a,
  output logic a_oe,
  output logic b_oe
);

  logic src_ok;

  always_comb begin
    src_is_a = dir_a2b;
    src_ok   = source_usable(dir_a2b, a_en);
    op       = pick_op(par_mode, async_par, src_ok);
    b_oe     = dir_a2b;
    a_oe     = a_en & ~dir_a2b;
  end

  always_comb begin
    p_oe_exclusive_r2: assert (!(a_oe && b_oe));
    p_a_gated_r3: assert (a_en || !a_oe);
  end

endmodule

// File: rtl/bxr_ports.sv
module bxr_ports #(
  parameter int WIDTH = 8
) (
  input  logic             src_is_a,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] src_word,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out
);

  always_comb begin
    src_word = src_is_a ? a_in : b_in;
    a_out    = word;
    b_out    = word;
  end

endmodule

// File: rtl/bxr_store.sv
module bxr_store
  import bxr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  op_e              op,
  input  logic [WIDTH-1:0] src_word,
  input  logic             ser_in,
  output logic [WIDTH-1:0] word,
  output logic             ser_out
);

  localparam int TOP = WIDTH - 1;

  function automatic logic [WIDTH-1:0] step_left(input logic [WIDTH-1:0] v,
                                                 input logic b);
    return {v[TOP-1:0], b};
  endfunction

  logic [WIDTH-1:0] q_ff;
  logic [WIDTH-1:0] q_lat;
  logic             hold_sel;
  logic [WIDTH-1:0] cur;
  logic             tracking;

  assign tracking = (op == OP_TRACK);
  assign cur      = hold_sel ? q_lat : q_ff;
  assign word     = tracking ? src_word : cur;
  assign ser_out  = word[TOP];

  // level-sensitive capture for the asynchronous parallel path
  always_latch begin
    if (tracking) q_lat <= src_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_ff     <= '0;
      hold_sel <= 1'b0;
    end else begin
      unique case (op)
        OP_TRACK: hold_sel <= 1'b1;
        OP_LOAD: begin
          q_ff     <= src_word;
          hold_sel <= 1'b0;
        end
        OP_SHIFT: begin
          q_ff     <= step_left(cur, ser_in);
          hold_sel <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (q_ff == '0 && !hold_sel));
  p_sync_load_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (q_ff == $past(src_word) && !hold_sel));
  p_shift_step_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SHIFT) |=> (q_ff[TOP:1] == $past(cur[TOP-1:0]) && q_ff[0] == $past(ser_in)));
  p_hold_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> ($stable(q_ff) && $stable(hold_sel)));
  p_track_select_r6: assert property (@(posedge clk) disable iff (rst)
    tracking |=> hold_sel);

  always_comb begin
    if (tracking) p_track_follow_r5: assert (word == src_word);
  end

endmodule

// File: rtl/bus_xfer_reg.sv
module bus_xfer_reg
  import bxr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_en,
  input  logic             dir_a2b,
  input  logic             par_mode,
  input  logic             async_par,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic             ser_out
);

  op_e              op;
  logic             src_is_a;
  logic [WIDTH-1:0] src_word;
  logic [WIDTH-1:0] word;

  bxr_ctrl u_ctrl (
    .a_en      (a_en),
    .dir_a2b   (dir_a2b),
    .par_mode  (par_mode),
    .async_par (async_par),
    .op        (op),
    .src_is_a  (src_is_a),
    .a_oe      (a_oe),
    .b_oe      (b_oe)
  );

  bxr_ports #(.WIDTH(WIDTH)) u_ports (
    .src_is_a (src_is_a),
    .a_in     (a_in),
    .b_in     (b_in),
    .word     (word),
    .src_word (src_word),
    .a_out    (a_out),
    .b_out    (b_out)
  );

  bxr_store #(.WIDTH(WIDTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .src_word (src_word),
    .ser_in   (ser_in),
    .word     (word),
    .ser_out  (ser_out)
  );

  p_ser_top_r9: assert property (@(posedge clk) disable iff (rst)
    (ser_out == a_out[WIDTH-1]) && (a_out == b_out));

endmodule

// File: tb/bus_xfer_reg_test.sv
module bus_xfer_reg_test;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, a_en, dir_a2b, par_mode, async_par, ser_in;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe, ser_out;

  int checks = 0;
  int errors = 0;
  int ref_word = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xfer_reg #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .a_en(a_en), .dir_a2b(dir_a2b),
    .par_mode(par_mode), .async_par(async_par), .ser_in(ser_in),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one cycle: drive after the falling edge, compare before the rising edge, then model the edge
  task automatic cycle(input string tag, input bit r, input bit ae, input bit d,
                       input bit p, input bit asy, input bit si,
                       input int av, input int bv);
    int src;
    bit usable;
    int vis;
    @(negedge clk);
    rst = r; a_en = ae; dir_a2b = d; par_mode = p; async_par = asy; ser_in = si;
    a_in = W'(av); b_in = W'(bv);
    #2;
    src    = d ? av : bv;
    usable = d ? ae : 1'b1;
    vis    = (p && asy && usable) ? src : ref_word;
    check(tag, "a_out", int'(a_out), vis);
    check(tag, "b_out", int'(b_out), vis);
    check(tag, "ser_out", int'(ser_out), (vis >> (W-1)) & 1);
    check("R2", "b_oe", int'(b_oe), int'(d));
    check("R3", "a_oe", int'(a_oe), int'(ae && !d));
    @(posedge clk);
    if (r)                  ref_word = 0;
    else if (!p)            ref_word = ((ref_word << 1) | int'(si)) & ((1 << W) - 1);
    else if (usable)        ref_word = src;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pat;
    rst = 1; a_en = 0; dir_a2b = 1; par_mode = 1; async_par = 0; ser_in = 0;
    a_in = 0; b_in = 0;
    // prime with nonzero content, then reset (R1)
    ref_word = 0;
    cycle("R1", 1, 1, 1, 1, 0, 0, 8'h00, 8'h00);
    cycle("R4", 0, 1, 1, 1, 0, 0, 8'hE7, 8'h00);
    cycle("R1", 1, 1, 1, 1, 0, 0, 8'h11, 8'h22);
    cycle("R1", 0, 0, 1, 1, 0, 0, 8'h33, 8'h44);
    // A to B and B to A (R2, R4)
    cycle("R4", 0, 1, 1, 1, 0, 0, 8'hA5, 8'h00);
    cycle("R2", 0, 1, 1, 1, 0, 0, 8'hA5, 8'h00);
    cycle("R4", 0, 1, 0, 1, 0, 0, 8'hFF, 8'h3C);
    cycle("R2", 0, 1, 0, 1, 0, 0, 8'hFF, 8'h3C);
    // port A disabled: no drive, no load from A (R3, R8)
    cycle("R3", 0, 0, 0, 1, 0, 0, 8'h00, 8'h3C);
    cycle("R3", 0, 0, 1, 1, 0, 0, 8'hFF, 8'h00);
    cycle("R8", 0, 0, 1, 1, 1, 0, 8'h81, 8'h00);
    cycle("R8", 0, 0, 1, 1, 0, 0, 8'h00, 8'h00);
    // asynchronous load then hold (R5, R6)
    cycle("R5", 0, 1, 1, 1, 1, 0, 8'h5A, 8'h00);
    cycle("R5", 0, 1, 1, 1, 1, 0, 8'h6B, 8'h00);
    cycle("R6", 0, 0, 1, 1, 0, 0, 8'h00, 8'h00);
    cycle("R6", 0, 0, 1, 1, 0, 0, 8'hC3, 8'h00);
    cycle("R5", 0, 1, 0, 1, 1, 0, 8'h00, 8'h9E);
    cycle("R6", 0, 1, 0, 1, 0, 0, 8'h00, 8'h9E);
    // serial in, msb first, async-select held high and ignored (R7)
    pat = 8'hD2;
    for (int i = W - 1; i >= 0; i--)
      cycle("R7", 0, 1, 1, 0, 1, (pat >> i) & 1, 8'hFF, 8'hFF);
    cycle("R9", 0, 0, 1, 1, 0, 0, 8'h00, 8'h00);
    check("R7", "serial fill", ref_word, 8'hD2);
    // load from B then recirculate a full pass (R7)
    cycle("R4", 0, 0, 0, 1, 0, 0, 8'h00, 8'h96);
    for (int i = 0; i < W; i++)
      cycle("R7", 0, 0, 0, 0, 0, (ref_word >> (W-1)) & 1, 8'h00, 8'h00);
    check("R7", "recirculate", ref_word, 8'h96);
    // shift out serially with zeros following
    for (int i = 0; i < W; i++)
      cycle("R7", 0, 1, 1, 0, 0, 0, 8'h00, 8'h00);
    cycle("R9", 0, 1, 0, 1, 0, 0, 8'h00, 8'h00);
    finish_run();
  end

endmodule